// File: doc/BRIEF.md
# Conditional Execution Check Unit

This block decides whether an instruction in a pipelined processor is allowed to take effect. It keeps a four-bit status register holding the negative (N), zero (Z), carry (C) and overflow (V) flags. It compares the instruction's four-bit condition field against those flags and drives one pass signal. The check is purely combinational, so the pass signal follows the condition field and the stored flags in the same cycle.

The status register takes a new set of flags from the arithmetic unit on a rising clock edge. That happens only when three things are true together: the instruction's flag-setting bit is high, the caller's update enable is high, and the instruction passes its own condition check. In every other case the register keeps its value. The ALU, the instruction decoder and pipeline flushing are outside this block. The decoder feeds the condition field and the flag-setting bit, and the pipeline uses the pass signal to squash writes.

Top module: `condExecUnit`

## Requirements
- R1: A synchronous active-high reset `rst` sets `flagsOut` to 4'b0000 at the next rising edge.
- R2: Codes 4'b0000/4'b0001 pass when Z is 1/0. Codes 4'b0010/4'b0011 pass when C is 1/0. Codes 4'b0100/4'b0101 pass when N is 1/0. Codes 4'b0110/4'b0111 pass when V is 1/0.
- R3: Code 4'b1000 passes when C is 1 and Z is 0. Code 4'b1001 passes when C is 0 or Z is 1.
- R4: Code 4'b1010 passes when N equals V. Code 4'b1011 passes when N differs from V.
- R5: Code 4'b1100 passes when Z is 0 and N equals V. Code 4'b1101 passes when Z is 1 or N differs from V.
- R6: Code 4'b1110 passes whatever the flags are. Code 4'b1111 never passes.
- R7: At a rising edge where `sBit`, `updEn` and `condPass` are all 1, the status register loads `aluFlags`.
- R8: At a rising edge where any of `sBit`, `updEn` or `condPass` is 0, the status register keeps its value.
- R9: Flag bit positions in both `aluFlags` and `flagsOut` are N=bit 3, Z=bit 2, C=bit 1, V=bit 0.
- R10: `condPass` is combinational. It reflects a change of `condField` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, clears the flags |
| condField | input | 4 | Condition bits of the current instruction |
| sBit | input | 1 | Flag-setting bit of the current instruction |
| updEn | input | 1 | Allows a flag load in this cycle |
| aluFlags | input | 4 | New flags from the ALU, order N Z C V |
| condPass | output | 1 | High when the instruction may execute |
| flagsOut | output | 4 | Current status register, order N Z C V |

## Verification
The clocked assertions assume that the inputs are at known values whenever reset is low. They also assume that `aluFlags` holds its value from the edge where a load is sampled until the next cycle's comparison. The bench meets both assumptions by driving every input just after a rising edge and holding it until the next one, with all ports at defined values before reset is released. The complement check between paired condition codes applies only once the flags are known, which means after the first reset edge. The stimulus never releases reset before that edge.

// File: rtl/condExecPkg.sv
package condExecPkg;
  localparam int FLAG_W   = 4;
  localparam int COND_W   = 4;
  localparam int NUM_COND = 1 << COND_W;
  localparam int NUM_PAIR = 4;

  // bit positions inside the status register (N Z C V, msb to lsb)
  localparam int IDX_N = 3;
  localparam int IDX_Z = 2;
  localparam int IDX_C = 1;
  localparam int IDX_V = 0;

  typedef enum logic [COND_W-1:0] {
    CC_ZSET   = 4'd0,
    CC_ZCLR   = 4'd1,
    CC_CSET   = 4'd2,
    CC_CCLR   = 4'd3,
    CC_NSET   = 4'd4,
    CC_NCLR   = 4'd5,
    CC_VSET   = 4'd6,
    CC_VCLR   = 4'd7,
    CC_UGT    = 4'd8,
    CC_ULE    = 4'd9,
    CC_SGE    = 4'd10,
    CC_SLT    = 4'd11,
    CC_SGT    = 4'd12,
    CC_SLE    = 4'd13,
    CC_ALWAYS = 4'd14,
    CC_NEVER  = 4'd15
  } condCodeT;

  typedef struct packed {
    logic clearFlags;
    logic loadFlags;
  } flagStrobeT;

  // flag tested by the k-th set/clear pair of condition codes
  function automatic int pairFlagIdx(input int k);
    case (k)
      0:       return IDX_Z;
      1:       return IDX_C;
      2:       return IDX_N;
      default: return IDX_V;
    endcase
  endfunction
endpackage

// File: rtl/condEval.sv
module condEval
  import condExecPkg::*;
(
  input  logic [FLAG_W-1:0] flags,
  input  logic [COND_W-1:0] condField,
  output logic              condPass
);
  logic [NUM_COND-1:0] predVec;
  logic nBit, zBit, cBit, vBit, signedGe;

  assign nBit     = flags[IDX_N];
  assign zBit     = flags[IDX_Z];
  assign cBit     = flags[IDX_C];
  assign vBit     = flags[IDX_V];
  assign signedGe = (nBit == vBit);

  // single-flag set/clear pairs
  for (genvar k = 0; k < NUM_PAIR; k++) begin : gPair
    localparam int FI = pairFlagIdx(k);
    assign predVec[2*k]   = flags[FI];
    assign predVec[2*k+1] = ~flags[FI];
  end

  // compound predicates
  always_comb begin
    predVec[CC_UGT]    = cBit & ~zBit;
    predVec[CC_ULE]    = ~cBit | zBit;
    predVec[CC_SGE]    = signedGe;
    predVec[CC_SLT]    = ~signedGe;
    predVec[CC_SGT]    = ~zBit & signedGe;
    predVec[CC_SLE]    = zBit | ~signedGe;
    predVec[CC_ALWAYS] = 1'b1;
    predVec[CC_NEVER]  = 1'b0;
  end

  assign condPass = predVec[condField];

  // R2 R3 R4 R5: each even code and the following odd code are complements
  always_comb begin
    if (!$isunknown(flags)) begin
      for (int k = 0; k < 7; k++) begin
        assert_pair_complement_R2: assert (predVec[2*k] != predVec[2*k+1]);
      end
    end
  end
endmodule

// File: rtl/flagCtrl.sv
module flagCtrl
  import condExecPkg::*;
(
  input  logic       rst,
  input  logic       sBit,
  input  logic       updEn,
  input  logic       condPass,
  output flagStrobeT strobe
);
  always_comb begin
    strobe.clearFlags = rst;
    strobe.loadFlags  = ~rst & sBit & updEn & condPass;
  end
endmodule

// File: rtl/flagReg.sv
module flagReg
  import condExecPkg::*;
(
  input  logic              clk,
  input  flagStrobeT        strobe,
  input  logic [FLAG_W-1:0] aluFlags,
  output logic [FLAG_W-1:0] flagsQ
);
  always_ff @(posedge clk) begin
    if (strobe.clearFlags)     flagsQ <= '0;
    else if (strobe.loadFlags) flagsQ <= aluFlags;
  end
endmodule

// File: rtl/condExecUnit.sv
module condExecUnit
  import condExecPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [COND_W-1:0] condField,
  input  logic              sBit,
  input  logic              updEn,
  input  logic [FLAG_W-1:0] aluFlags,
  output logic              condPass,
  output logic [FLAG_W-1:0] flagsOut
);
  flagStrobeT strobe;
  logic [FLAG_W-1:0] flagsQ;

  condEval uEval (
    .flags     (flagsQ),
    .condField (condField),
    .condPass  (condPass)
  );

  flagCtrl uCtrl (
    .rst      (rst),
    .sBit     (sBit),
    .updEn    (updEn),
    .condPass (condPass),
    .strobe   (strobe)
  );

  flagReg uReg (
    .clk      (clk),
    .strobe   (strobe),
    .aluFlags (aluFlags),
    .flagsQ   (flagsQ)
  );

  assign flagsOut = flagsQ;

  assert_load_R7: assert property (@(posedge clk) disable iff (rst)
    (sBit && updEn && condPass) |=> (flagsOut == $past(aluFlags)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(sBit && updEn && condPass) |=> $stable(flagsOut));

  assert_always_R6: assert property (@(posedge clk) disable iff (rst)
    (condField == CC_ALWAYS) |-> condPass);

  assert_never_R6: assert property (@(posedge clk) disable iff (rst)
    (condField == CC_NEVER) |-> !condPass);

  // R5: signed greater-than never passes while Z is set
  assert_sgt_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (condField == CC_SGT && flagsOut[IDX_Z]) |-> !condPass);
endmodule

// File: tb/tb_condExecUnit.sv
module tb_condExecUnit;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] condField;
  logic       sBit;
  logic       updEn;
  logic [3:0] aluFlags;
  logic       condPass;
  logic [3:0] flagsOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  condExecUnit dut (
    .clk(clk), .rst(rst), .condField(condField), .sBit(sBit),
    .updEn(updEn), .aluFlags(aluFlags), .condPass(condPass), .flagsOut(flagsOut)
  );

  // vector: flags {N,Z,C,V}, condition code, expected pass
  typedef struct packed {
    logic [3:0] fl;
    logic [3:0] cc;
    logic       ex;
  } vecT;

  localparam int NV = 22;
  localparam vecT VECS [NV] = '{
    '{4'b0100, 4'h0, 1'b1}, '{4'b0000, 4'h0, 1'b0}, '{4'b0000, 4'h1, 1'b1},
    '{4'b0010, 4'h2, 1'b1}, '{4'b0000, 4'h3, 1'b1}, '{4'b1000, 4'h4, 1'b1},
    '{4'b1000, 4'h5, 1'b0}, '{4'b0001, 4'h6, 1'b1}, '{4'b0001, 4'h7, 1'b0},
    '{4'b0010, 4'h8, 1'b1}, '{4'b0110, 4'h8, 1'b0}, '{4'b0110, 4'h9, 1'b1},
    '{4'b0010, 4'h9, 1'b0}, '{4'b1001, 4'hA, 1'b1}, '{4'b1000, 4'hA, 1'b0},
    '{4'b1000, 4'hB, 1'b1}, '{4'b0000, 4'hC, 1'b1}, '{4'b0100, 4'hC, 1'b0},
    '{4'b1000, 4'hD, 1'b1}, '{4'b0000, 4'hD, 1'b0}, '{4'b1111, 4'hE, 1'b1},
    '{4'b1111, 4'hF, 1'b0}
  };

  function automatic string reqOf(input logic [3:0] cc);
    if (cc < 4'h8)       return "R2";
    else if (cc < 4'hA)  return "R3";
    else if (cc < 4'hC)  return "R4";
    else if (cc < 4'hE)  return "R5";
    else                 return "R6";
  endfunction

  function automatic logic refPass(input logic [3:0] f, input logic [3:0] cc);
    logic n, z, c, v;
    n = f[3]; z = f[2]; c = f[1]; v = f[0];
    case (cc)
      4'h0: return z;          4'h1: return !z;
      4'h2: return c;          4'h3: return !c;
      4'h4: return n;          4'h5: return !n;
      4'h6: return v;          4'h7: return !v;
      4'h8: return c && !z;    4'h9: return !c || z;
      4'hA: return n == v;     4'hB: return n != v;
      4'hC: return !z && (n == v);
      4'hD: return z || (n != v);
      4'hE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp, input string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // load flags through an always-pass instruction
  task automatic loadFlags(input logic [3:0] f);
    condField = 4'hE; sBit = 1'b1; updEn = 1'b1; aluFlags = f;
    tick();
    sBit = 1'b0; updEn = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; condField = 4'hE; sBit = 1'b0; updEn = 1'b0; aluFlags = 4'hF;
    tick(); tick();
    // R1: reset state
    check("R1", flagsOut, 4'b0000, "flags after reset");
    rst = 1'b0;
    condField = 4'h0; #1;
    check("R2", {3'b0, condPass}, 4'd0, "Z-set test on cleared flags");
    condField = 4'h1; #1;
    check("R10", {3'b0, condPass}, 4'd1, "pass follows condField without edge");

    // table walk
    for (int i = 0; i < NV; i++) begin
      loadFlags(VECS[i].fl);
      condField = VECS[i].cc; #1;
      check(reqOf(VECS[i].cc), {3'b0, condPass}, {3'b0, VECS[i].ex},
            $sformatf("vector %0d", i));
    end

    // exhaustive sweep against the bench model
    for (int f = 0; f < 16; f++) begin
      loadFlags(f[3:0]);
      check("R7", flagsOut, f[3:0], "flag load under always code");
      for (int c = 0; c < 16; c++) begin
        condField = c[3:0]; #1;
        check(reqOf(c[3:0]), {3'b0, condPass}, {3'b0, refPass(f[3:0], c[3:0])},
              $sformatf("sweep flags %0d code %0d", f, c));
      end
    end

    // R9: bit order, N alone in bit 3
    loadFlags(4'b1000);
    condField = 4'h4; #1;
    check("R9", {3'b0, condPass}, 4'd1, "N at bit 3 seen by minus code");
    condField = 4'h0; #1;
    check("R9", {3'b0, condPass}, 4'd0, "Z clear when only bit 3 set");

    // R8: no load when sBit low
    loadFlags(4'b0101);
    condField = 4'hE; sBit = 1'b0; updEn = 1'b1; aluFlags = 4'b1010;
    tick();
    check("R8", flagsOut, 4'b0101, "hold with sBit low");
    // R8: no load when updEn low
    sBit = 1'b1; updEn = 1'b0;
    tick();
    check("R8", flagsOut, 4'b0101, "hold with updEn low");
    // R8: no load when condition fails
    updEn = 1'b1; condField = 4'h1;
    tick();
    check("R8", flagsOut, 4'b0101, "hold with failing condition");
    condField = 4'hF;
    tick();
    check("R8", flagsOut, 4'b0101, "hold with never code");
    // R7: load under a passing non-always condition (Z set, code 0000)
    condField = 4'h0; aluFlags = 4'b0010;
    tick();
    check("R7", flagsOut, 4'b0010, "load under passing equal code");
    sBit = 1'b0; updEn = 1'b0;

    // R1: reset mid-run, with a load requested in the same cycle
    loadFlags(4'b1111);
    rst = 1'b1; condField = 4'hE; sBit = 1'b1; updEn = 1'b1; aluFlags = 4'b1111;
    tick();
    check("R1", flagsOut, 4'b0000, "reset overrides load");
    rst = 1'b0; sBit = 1'b0; updEn = 1'b0;
    tick();
    check("R1", flagsOut, 4'b0000, "flags stay clear after reset");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule